// File: doc/BRIEF.md
# MDIO PHY Presence and Link Tracker

This block keeps two status vectors for a management bus on which up to 32 PHYs can sit. Each vector has one bit per PHY address. A separate MDIO engine performs the serial transfers. For each transfer it finishes, it reports the result as a one-cycle completion pulse with sideband fields: the PHY address, whether the transfer was a read of the PHY's basic status register, whether the PHY acknowledged, and the link-up bit that was read back.

From each completion the tracker updates a presence vector and a link vector. The presence vector records whether the PHY answered its most recent access. The link vector records whether the PHY answered a status read and also reported link. Software can read either vector through a small register port, and can clear presence bits by writing ones.

Two selection slots each name a PHY address. A slot can hand that PHY's link bit over to an external link pin. The pin passes through a synchronizer before it reaches the link bit.

Top module: `mdio_status_tracker`

## Requirements
- R1: After a synchronous active-low reset, both vectors read as all zeros and `reg_rvalid` is low.
- R2: On a completion pulse for PHY address n, presence bit n takes the value of `txn_ack` at the next clock edge. All other presence bits keep their values.
- R3: Presence bits are updated by every completion, whatever kind of transfer it was. This includes writes and reads of registers other than the basic status register.
- R4: A register write to address 0 (presence vector) clears each presence bit whose `reg_wdata` bit is 1. Bits whose `reg_wdata` bit is 0 are left unchanged.
- R5: A completion with `txn_is_status_rd` low leaves the link vector unchanged.
- R6: On a completion with `txn_is_status_rd` high for PHY n, link bit n becomes `txn_ack & txn_link_up`.
- R7: A register write to address 1 (link vector) has no effect on either vector.
- R8: While `slot_pin_en[k]` is high, the link bit at address `slot_phy[k]` follows `link_pin[k]` through a two-flop synchronizer. A pin level applied just after edge 0 appears on the link bit at edge 3, and MDIO status reads for that address are ignored. When the slot is released, the bit keeps its last value.
- R9: If a completion and a presence-vector write fall in the same cycle, the completion decides the bit of its own PHY. The write still clears the other masked bits.
- R10: A read with `reg_rd` high at an edge returns the selected vector (address 0 presence, address 1 link) as it stood before that edge. The data appears on `reg_rdata` with `reg_rvalid` high for one cycle after that edge. Reads have no side effects.
- R11: When both slots are enabled on the same PHY address, slot 1 supplies the link bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_done | input | 1 | One-cycle completion pulse from the MDIO engine |
| txn_phy | input | 5 | PHY address of the completed transfer |
| txn_is_status_rd | input | 1 | Transfer was a read of the basic status register |
| txn_ack | input | 1 | PHY acknowledged the transfer |
| txn_link_up | input | 1 | Link-up bit read back |
| slot_phy | input | 2x5 | PHY address of each selection slot |
| slot_pin_en | input | 2 | Per-slot select: link taken from pin |
| link_pin | input | 2 | Asynchronous link pins, one per slot |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = presence vector, 1 = link vector |
| reg_wdata | input | 32 | Write data (ones clear presence bits) |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |

## Verification
Two functions can act on the same presence bit in one cycle: a transaction completion and a write-one-to-clear. The bench provokes this by pulsing `txn_done` in the same cycle as a presence write whose mask covers the completing PHY and a neighbour. It then reads the vector back and expects the completing PHY's bit to follow its acknowledge while the neighbour is cleared. Pin override and an MDIO status read for the same address are also overlapped, and the pin level is expected to win.

// File: rtl/mst_pkg.sv
// Package: shared definitions for the MDIO presence/link tracker.
// Assumes a single-bit register address space holding two vectors.
package mst_pkg;
    typedef enum logic {
        REG_PRESENCE = 1'b0,
        REG_LINK     = 1'b1
    } mst_reg_e;
endpackage

// File: rtl/mst_pin_sync.sv
// Module: multi-stage synchronizer for one asynchronous link pin.
// Assumes the pin is quasi-static relative to clk; resets to low.
module mst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mst_presence_vec.sv
// Module: presence vector, one bit per PHY address.
// Assumes at most one completion per cycle; the completion outranks a
// same-cycle write-one-to-clear for its own bit.
module mst_presence_vec #(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_done,
    input  logic [AW-1:0] txn_phy,
    input  logic          txn_ack,
    input  logic          clr_en,
    input  logic [N-1:0]  clr_mask,
    output logic [N-1:0]  presence_q
);
    logic [N-1:0] presence_d;

    // Apply the clear mask first, then let the completion overwrite its bit.
    always_comb begin
        presence_d = presence_q;
        if (clr_en)   presence_d = presence_d & ~clr_mask;
        if (txn_done) presence_d[txn_phy] = txn_ack;
    end

    // Register the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) presence_q <= '0;
        else        presence_q <= presence_d;
    end

    assert_presence_follows_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> presence_q[$past(txn_phy)] == $past(txn_ack));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !txn_done) |=> ((presence_q & $past(clr_mask)) == '0));

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !txn_done) |=> $stable(presence_q));
endmodule

// File: rtl/mst_link_vec.sv
// Module: link vector, one bit per PHY address.
// Assumes at most one completion per cycle. Pin-driven slots override
// MDIO status reads, and a higher slot index overrides a lower one.
module mst_link_vec #(
    parameter int N     = 32,
    parameter int AW    = 5,
    parameter int SLOTS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      txn_done,
    input  logic                      txn_is_status_rd,
    input  logic                      txn_ack,
    input  logic                      txn_link_up,
    input  logic [AW-1:0]             txn_phy,
    input  logic [SLOTS-1:0][AW-1:0]  slot_phy,
    input  logic [SLOTS-1:0]          slot_en,
    input  logic [SLOTS-1:0]          slot_lvl,
    output logic [N-1:0]              link_q
);
    logic [N-1:0] link_d;

    // MDIO status-read result first, then pin slots in ascending priority.
    always_comb begin
        link_d = link_q;
        if (txn_done && txn_is_status_rd) link_d[txn_phy] = txn_ack & txn_link_up;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_en[k]) link_d[slot_phy[k]] = slot_lvl[k];
        end
    end

    // Register the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= '0;
        else        link_q <= link_d;
    end

    assert_link_ack_and_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_is_status_rd && slot_en == '0)
        |=> link_q[$past(txn_phy)] == ($past(txn_ack) && $past(txn_link_up)));

    assert_non_status_keeps_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(txn_done && txn_is_status_rd) && slot_en == '0) |=> $stable(link_q));

    assert_top_slot_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[SLOTS-1] |=> link_q[$past(slot_phy[SLOTS-1])] == $past(slot_lvl[SLOTS-1]));
endmodule

// File: rtl/mst_reg_port.sv
// Module: register port decode and registered read mux.
// Assumes one-cycle read latency; reads have no side effects.
module mst_reg_port
    import mst_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic         reg_addr,
    input  logic [N-1:0] presence_q,
    input  logic [N-1:0] link_q,
    output logic         presence_clr_en,
    output logic [N-1:0] reg_rdata,
    output logic         reg_rvalid
);
    // Only the presence vector accepts writes; link writes are dropped.
    assign presence_clr_en = reg_wr && (mst_reg_e'(reg_addr) == REG_PRESENCE);

    // Capture the selected vector and raise valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= (mst_reg_e'(reg_addr) == REG_LINK) ? link_q : presence_q;
        end
    end

    assert_rvalid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_rvalid_only_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
endmodule

// File: rtl/mdio_status_tracker.sv
// Module: top of the MDIO PHY presence and link tracker.
// Assumes the MDIO engine issues at most one completion pulse per cycle
// and that link pins are asynchronous to clk.
module mdio_status_tracker #(
    parameter int PHY_CNT     = 32,
    parameter int SLOT_CNT    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PHY_AW     = $clog2(PHY_CNT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          txn_done,
    input  logic [PHY_AW-1:0]             txn_phy,
    input  logic                          txn_is_status_rd,
    input  logic                          txn_ack,
    input  logic                          txn_link_up,
    input  logic [SLOT_CNT-1:0][PHY_AW-1:0] slot_phy,
    input  logic [SLOT_CNT-1:0]           slot_pin_en,
    input  logic [SLOT_CNT-1:0]           link_pin,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic                          reg_addr,
    input  logic [PHY_CNT-1:0]            reg_wdata,
    output logic [PHY_CNT-1:0]            reg_rdata,
    output logic                          reg_rvalid
);
    logic [PHY_CNT-1:0]  presence_q;
    logic [PHY_CNT-1:0]  link_q;
    logic [SLOT_CNT-1:0] pin_lvl;
    logic                presence_clr_en;

    for (genvar k = 0; k < SLOT_CNT; k++) begin : g_sync
        mst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (link_pin[k]),
            .pin_sync  (pin_lvl[k])
        );
    end

    mst_presence_vec #(.N(PHY_CNT), .AW(PHY_AW)) u_presence (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_done   (txn_done),
        .txn_phy    (txn_phy),
        .txn_ack    (txn_ack),
        .clr_en     (presence_clr_en),
        .clr_mask   (reg_wdata),
        .presence_q (presence_q)
    );

    mst_link_vec #(.N(PHY_CNT), .AW(PHY_AW), .SLOTS(SLOT_CNT)) u_link (
        .clk              (clk),
        .rst_n            (rst_n),
        .txn_done         (txn_done),
        .txn_is_status_rd (txn_is_status_rd),
        .txn_ack          (txn_ack),
        .txn_link_up      (txn_link_up),
        .txn_phy          (txn_phy),
        .slot_phy         (slot_phy),
        .slot_en          (slot_pin_en),
        .slot_lvl         (pin_lvl),
        .link_q           (link_q)
    );

    mst_reg_port #(.N(PHY_CNT)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_rd          (reg_rd),
        .reg_addr        (reg_addr),
        .presence_q      (presence_q),
        .link_q          (link_q),
        .presence_clr_en (presence_clr_en),
        .reg_rdata       (reg_rdata),
        .reg_rvalid      (reg_rvalid)
    );

    assert_link_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && !txn_done && slot_pin_en == '0)
        |=> ($stable(link_q) && $stable(presence_q)));

    assert_any_txn_updates_presence_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !txn_is_status_rd) |=> presence_q[$past(txn_phy)] == $past(txn_ack));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (presence_q == '0 && link_q == '0 && !reg_rvalid));
endmodule

// File: tb/mdio_status_tracker_tb.sv
module mdio_status_tracker_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_done = 1'b0;
    logic [4:0] txn_phy = '0;
    logic txn_is_status_rd = 1'b0;
    logic txn_ack = 1'b0;
    logic txn_link_up = 1'b0;
    logic [1:0][4:0] slot_phy = '0;
    logic [1:0] slot_pin_en = '0;
    logic [1:0] link_pin = '0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic reg_rvalid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pres = '0;
    logic [31:0] exp_link = '0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_status_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_phy(txn_phy),
        .txn_is_status_rd(txn_is_status_rd), .txn_ack(txn_ack), .txn_link_up(txn_link_up),
        .slot_phy(slot_phy), .slot_pin_en(slot_pin_en), .link_pin(link_pin),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    // Monitor: pop expected read data whenever the design returns a read.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected rvalid, data %h expected no read", reg_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic do_read(input logic addr, input logic [31:0] e, input string t);
        reg_rd = 1'b1; reg_addr = addr;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_txn(input logic [4:0] phy, input logic st, input logic ack,
                          input logic up, input logic model_link);
        txn_done = 1'b1; txn_phy = phy; txn_is_status_rd = st; txn_ack = ack; txn_link_up = up;
        @(negedge clk);
        txn_done = 1'b0;
        exp_pres[phy] = ack;
        if (st && model_link) exp_link[phy] = ack & up;
    endtask

    task automatic do_write(input logic addr, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (addr == 1'b0) exp_pres = exp_pres & ~d;
    endtask

    task automatic plain_check(input logic got, input logic e, input string t);
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, got, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        plain_check(reg_rvalid, 1'b0, "R1 rvalid after reset");
        do_read(1'b0, 32'h0, "R1 presence reset");
        do_read(1'b1, 32'h0, "R1 link reset");

        // R2/R3/R5: non-status access updates presence only.
        do_txn(5'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        do_read(1'b0, exp_pres, "R3 presence after non-status access");
        do_read(1'b1, exp_link, "R5 link unchanged by non-status access");

        // R6: status reads at boundary addresses.
        do_txn(5'd31, 1'b1, 1'b1, 1'b1, 1'b1);
        do_txn(5'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        do_read(1'b1, exp_link, "R6 link ack and up, addr 31 and 0");
        do_txn(5'd31, 1'b1, 1'b0, 1'b1, 1'b1);
        do_read(1'b1, exp_link, "R6 link cleared on no ack");
        do_read(1'b0, exp_pres, "R2 presence cleared on no ack");
        do_txn(5'd10, 1'b1, 1'b1, 1'b1, 1'b1);
        do_txn(5'd10, 1'b0, 1'b0, 1'b0, 1'b1);
        do_read(1'b1, exp_link, "R5 link kept after failed non-status access");
        do_read(1'b0, exp_pres, "R2 presence follows latest ack");

        // R4: write-one-to-clear, write zero no effect.
        do_txn(5'd4, 1'b0, 1'b1, 1'b0, 1'b1);
        do_write(1'b0, 32'h0000_0018);
        do_read(1'b0, exp_pres, "R4 presence w1c");
        do_write(1'b0, 32'h0);
        do_read(1'b0, exp_pres, "R4 presence write zero");

        // R7: link writes ignored.
        do_write(1'b1, 32'hFFFF_FFFF);
        do_read(1'b1, exp_link, "R7 link write ignored");
        do_read(1'b0, exp_pres, "R7 presence untouched by link write");

        // R9: completion and w1c in the same cycle.
        do_txn(5'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        do_txn(5'd4, 1'b0, 1'b1, 1'b0, 1'b1);
        txn_done = 1'b1; txn_phy = 5'd3; txn_is_status_rd = 1'b0; txn_ack = 1'b1;
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0000_0018;
        @(negedge clk);
        txn_done = 1'b0; reg_wr = 1'b0;
        exp_pres[4] = 1'b0; exp_pres[3] = 1'b1;
        do_read(1'b0, exp_pres, "R9 completion wins over same-cycle clear");

        // R10: back-to-back reads, no side effects.
        do_read(1'b0, exp_pres, "R10 first read");
        do_read(1'b0, exp_pres, "R10 repeated read unchanged");

        // R8: pin override timing through the synchronizer.
        slot_phy[0] = 5'd5; slot_pin_en = 2'b01; link_pin = 2'b01;
        @(negedge clk);
        @(negedge clk);
        do_read(1'b1, exp_link, "R8 link not yet visible before third edge");
        exp_link[5] = 1'b1;
        do_read(1'b1, exp_link, "R8 link follows pin after synchronizer");
        do_txn(5'd5, 1'b1, 1'b0, 1'b0, 1'b0);
        do_read(1'b1, exp_link, "R8 MDIO read ignored on pin-driven bit");
        slot_pin_en = 2'b00;
        @(negedge clk);
        do_read(1'b1, exp_link, "R8 bit retained after release");

        // R11: both slots on the same address, slot 1 wins.
        slot_phy[0] = 5'd20; slot_phy[1] = 5'd20; link_pin = 2'b10; slot_pin_en = 2'b11;
        repeat (4) @(negedge clk);
        exp_link[20] = 1'b1;
        do_read(1'b1, exp_link, "R11 slot 1 drives shared address");
        slot_pin_en = 2'b00;

        repeat (3) @(negedge clk);
        plain_check(exp_q.size() == 0, 1'b1, "R10 all reads returned");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule